// File: doc/BRIEF.md
# Audio Serial Bus Clock Generator

This block produces the bit clock and the frame (word) clock of a serial audio bus when the local interface drives those clocks. A fast reference clock is divided by a programmable ratio to form the bit clock. A second counter counts a programmable number of bit periods per frame to form the word clock, whose rate is the sample rate. The word clock is either a one-bit-period pulse at the start of each frame or a square wave that is high for the first half of the frame.

Each clock has its own drive enable, so either line can be left to another device. Both clocks run only while the converter is powered up, or while a keep-alive control holds them on with the converter down. This keeps a shared time-division bus alive, or lets the clocks be used as general-purpose clocks.

Stopping and starting happen only at frame boundaries, so no shortened pulse ever appears on either line. Ratio, frame length, shape and drive enables are taken in once per frame. As a result, software can change them at any time without corrupting the frame in progress.

Top module: `audio_clkgen_top`

## Requirements
- R1: The bit clock period is `bclk_ratio_i` reference clock cycles; ratio values 0 and 1 are treated as 2.
- R2: In each bit period the bit clock is high for the first floor(ratio/2) reference cycles and low for the rest (50% duty for even ratios).
- R3: A frame holds `frame_bits_i` bit periods (values 0 and 1 treated as 2), so the word clock period is frame_bits x ratio reference cycles.
- R4: With `wclk_square_i` = 0 (pulse shape) the word clock is high for exactly one bit period, rising together with the first bit clock rise of the frame.
- R5: With `wclk_square_i` = 1 (square shape) the word clock is high for the first floor(frame_bits/2) bit periods of the frame.
- R6: When `bclk_master_i` is 0 the bit clock output stays low; when `wclk_master_i` is 0 the word clock output stays low; the other clock keeps running unaffected.
- R7: The clocks run only while `pwr_up_i` or `keep_alive_i` is 1; with both 0 and the generator idle, both outputs stay low.
- R8: When both `pwr_up_i` and `keep_alive_i` go to 0 mid-frame, the frame in progress completes and both clocks then stop low at the frame boundary.
- R9: From idle, the output on the first reference clock edge that sees `pwr_up_i` or `keep_alive_i` high starts a new frame, with bit clock and word clock both high.
- R10: Ratio, frame length, shape and drive enables are sampled only at frame start; changes made mid-frame take effect from the next frame.
- R11: An active-low asynchronous reset forces both outputs low at once and leaves the generator idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock that is divided down |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Converter powered up; enables the clocks |
| keep_alive_i | input | 1 | Keeps the clocks running while the converter is down |
| bclk_master_i | input | 1 | Drive the bit clock line from this block |
| wclk_master_i | input | 1 | Drive the word clock line from this block |
| wclk_square_i | input | 1 | Word clock shape: 0 pulse, 1 square |
| bclk_ratio_i | input | DIV_W | Reference cycles per bit period |
| frame_bits_i | input | FRM_W | Bit periods per frame |
| bclk_o | output | 1 | Generated bit clock |
| wclk_o | output | 1 | Generated word clock |

## Verification
A table of seven settings drives the divider and frame counter, covering even and odd ratios, both word clock shapes, odd and even frame lengths, and the clamped values 0 and 1. From each run the bench measures the bit period, the bit high time, the frame length in cycles and in bit rises, and the word clock high time. Together these tell apart duty errors, off-by-one wrap points and a wrong halving of odd frames. Directed patterns then cover one drive enable off at a time, keep-alive against power-down, a stop requested in the middle of a frame, a restart, a frame length changed mid-frame, and a reset asserted while running.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // word clock shape selection (value of the shape input)
  typedef enum logic {
    WSHAPE_PULSE  = 1'b0,
    WSHAPE_SQUARE = 1'b1
  } wshape_e;

  // run/idle state of the generator
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_RUN  = 1'b1
  } gate_e;

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [FRM_W-1:0] frm_i,
  input  logic             square_i,
  input  logic             bm_i,
  input  logic             wm_i,
  output logic [DIV_W-1:0] div_n_o,
  output logic [FRM_W-1:0] frm_n_o,
  output wshape_e          shape_n_o,
  output logic             bm_n_o,
  output logic             wm_n_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic [FRM_W-1:0] frm_q_o,
  output wshape_e          shape_q_o,
  output logic             bm_q_o,
  output logic             wm_q_o
);

  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [FRM_W-1:0] FRM_MIN = FRM_W'(2);

  logic [DIV_W-1:0] div_clamped;
  logic [FRM_W-1:0] frm_clamped;

  // clamp the programmable values to their legal minimum
  always_comb begin
    div_clamped = (div_i < DIV_MIN) ? DIV_MIN : div_i;
    frm_clamped = (frm_i < FRM_MIN) ? FRM_MIN : frm_i;
  end

  // next state: take new settings only when the gate asks for it
  always_comb begin
    div_n_o   = div_q_o;
    frm_n_o   = frm_q_o;
    shape_n_o = shape_q_o;
    bm_n_o    = bm_q_o;
    wm_n_o    = wm_q_o;
    if (load_i) begin
      div_n_o   = div_clamped;
      frm_n_o   = frm_clamped;
      shape_n_o = square_i ? WSHAPE_SQUARE : WSHAPE_PULSE;
      bm_n_o    = bm_i;
      wm_n_o    = wm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q_o   <= DIV_MIN;
      frm_q_o   <= FRM_MIN;
      shape_q_o <= WSHAPE_PULSE;
      bm_q_o    <= 1'b0;
      wm_q_o    <= 1'b0;
    end else begin
      div_q_o   <= div_n_o;
      frm_q_o   <= frm_n_o;
      shape_q_o <= shape_n_o;
      bm_q_o    <= bm_n_o;
      wm_q_o    <= wm_n_o;
    end
  end

endmodule

// File: rtl/audio_clkgen_gate.sv
module audio_clkgen_gate
  import audio_clkgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  input  logic keep_alive_i,
  input  logic frame_end_i,
  output logic active_q_o,
  output logic active_n_o,
  output logic start_n_o,
  output logic load_n_o
);

  gate_e state_q;
  gate_e state_n;
  logic  run_req;

  assign run_req = pwr_up_i | keep_alive_i;

  // stop and start only on frame boundaries
  always_comb begin
    state_n   = state_q;
    start_n_o = 1'b0;
    unique case (state_q)
      GATE_IDLE: begin
        if (run_req) begin
          state_n   = GATE_RUN;
          start_n_o = 1'b1;
        end
      end
      GATE_RUN: begin
        if (frame_end_i) begin
          if (run_req) begin
            start_n_o = 1'b1;
          end else begin
            state_n = GATE_IDLE;
          end
        end
      end
      default: state_n = GATE_IDLE;
    endcase
  end

  assign active_q_o = (state_q == GATE_RUN);
  assign active_n_o = (state_n == GATE_RUN);
  // settings follow the inputs while idle and are frozen during a frame
  assign load_n_o   = start_n_o | (state_q == GATE_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

endmodule

// File: rtl/audio_clkgen_cnt.sv
module audio_clkgen_cnt #(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_q_i,
  input  logic             active_n_i,
  input  logic             start_n_i,
  input  logic [DIV_W-1:0] div_eff_i,
  input  logic [FRM_W-1:0] frm_eff_i,
  output logic [DIV_W-1:0] div_cnt_q_o,
  output logic [FRM_W-1:0] bit_cnt_q_o,
  output logic [DIV_W-1:0] div_cnt_n_o,
  output logic [FRM_W-1:0] bit_cnt_n_o,
  output logic             frame_end_o
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [FRM_W-1:0] FRM_ONE = FRM_W'(1);

  logic div_last;
  logic bit_last;
  logic cnt_en;

  assign div_last    = (div_cnt_q_o == div_eff_i - DIV_ONE);
  assign bit_last    = (bit_cnt_q_o == frm_eff_i - FRM_ONE);
  assign frame_end_o = active_q_i & div_last & bit_last;
  assign cnt_en      = active_n_i & ~start_n_i;

  always_comb begin
    div_cnt_n_o = '0;
    bit_cnt_n_o = '0;
    if (cnt_en) begin
      if (div_last) begin
        bit_cnt_n_o = bit_cnt_q_o + FRM_ONE;
      end else begin
        div_cnt_n_o = div_cnt_q_o + DIV_ONE;
        bit_cnt_n_o = bit_cnt_q_o;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q_o <= '0;
      bit_cnt_q_o <= '0;
    end else begin
      div_cnt_q_o <= div_cnt_n_o;
      bit_cnt_q_o <= bit_cnt_n_o;
    end
  end

endmodule

// File: rtl/audio_clkgen_shape.sv
module audio_clkgen_shape
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_n_i,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic [FRM_W-1:0] frm_n_i,
  input  wshape_e          shape_n_i,
  input  logic             bm_n_i,
  input  logic             wm_n_i,
  input  logic [DIV_W-1:0] div_cnt_n_i,
  input  logic [FRM_W-1:0] bit_cnt_n_i,
  output logic             bclk_o,
  output logic             wclk_o
);

  logic bclk_n;
  logic wclk_n;
  logic wclk_level;

  // word clock level picked by the shape variant
  always_comb begin
    unique case (shape_n_i)
      WSHAPE_SQUARE: wclk_level = (bit_cnt_n_i < (frm_n_i >> 1));
      default:       wclk_level = (bit_cnt_n_i == '0);
    endcase
  end

  // outputs registered from next state so they never decode glitches
  always_comb begin
    bclk_n = active_n_i & bm_n_i & (div_cnt_n_i < (div_n_i >> 1));
    wclk_n = active_n_i & wm_n_i & wclk_level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_o <= 1'b0;
      wclk_o <= 1'b0;
    end else begin
      bclk_o <= bclk_n;
      wclk_o <= wclk_n;
    end
  end

endmodule

// File: rtl/audio_clkgen_top.sv
module audio_clkgen_top
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             keep_alive_i,
  input  logic             bclk_master_i,
  input  logic             wclk_master_i,
  input  logic             wclk_square_i,
  input  logic [DIV_W-1:0] bclk_ratio_i,
  input  logic [FRM_W-1:0] frame_bits_i,
  output logic             bclk_o,
  output logic             wclk_o
);

  logic             active_q;
  logic             active_n;
  logic             start_n;
  logic             load_n;
  logic             frame_end;
  logic [DIV_W-1:0] div_n;
  logic [FRM_W-1:0] frm_n;
  wshape_e          shape_n;
  logic             bm_n;
  logic             wm_n;
  logic [DIV_W-1:0] div_q;
  logic [FRM_W-1:0] frm_q;
  wshape_e          shape_q;
  logic             bm_q;
  logic             wm_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [FRM_W-1:0] bit_cnt_q;
  logic [DIV_W-1:0] div_cnt_n;
  logic [FRM_W-1:0] bit_cnt_n;

  audio_clkgen_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_up_i     (pwr_up_i),
    .keep_alive_i (keep_alive_i),
    .frame_end_i  (frame_end),
    .active_q_o   (active_q),
    .active_n_o   (active_n),
    .start_n_o    (start_n),
    .load_n_o     (load_n)
  );

  audio_clkgen_cfg #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_n),
    .div_i     (bclk_ratio_i),
    .frm_i     (frame_bits_i),
    .square_i  (wclk_square_i),
    .bm_i      (bclk_master_i),
    .wm_i      (wclk_master_i),
    .div_n_o   (div_n),
    .frm_n_o   (frm_n),
    .shape_n_o (shape_n),
    .bm_n_o    (bm_n),
    .wm_n_o    (wm_n),
    .div_q_o   (div_q),
    .frm_q_o   (frm_q),
    .shape_q_o (shape_q),
    .bm_q_o    (bm_q),
    .wm_q_o    (wm_q)
  );

  audio_clkgen_cnt #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_q_i  (active_q),
    .active_n_i  (active_n),
    .start_n_i   (start_n),
    .div_eff_i   (div_q),
    .frm_eff_i   (frm_q),
    .div_cnt_q_o (div_cnt_q),
    .bit_cnt_q_o (bit_cnt_q),
    .div_cnt_n_o (div_cnt_n),
    .bit_cnt_n_o (bit_cnt_n),
    .frame_end_o (frame_end)
  );

  audio_clkgen_shape #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_shape (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_n_i  (active_n),
    .div_n_i     (div_n),
    .frm_n_i     (frm_n),
    .shape_n_i   (shape_n),
    .bm_n_i      (bm_n),
    .wm_n_i      (wm_n),
    .div_cnt_n_i (div_cnt_n),
    .bit_cnt_n_i (bit_cnt_n),
    .bclk_o      (bclk_o),
    .wclk_o      (wclk_o)
  );

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_up_i,
  input logic             keep_alive_i,
  input logic             active_q,
  input logic             frame_end,
  input logic [DIV_W-1:0] div_q,
  input logic [FRM_W-1:0] frm_q,
  input wshape_e          shape_q,
  input logic             bm_q,
  input logic             wm_q,
  input logic [DIV_W-1:0] div_cnt_q,
  input logic [FRM_W-1:0] bit_cnt_q,
  input logic             bclk_o,
  input logic             wclk_o
);

  // R1: divider count stays inside the programmed period
  a_r1_div_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (div_cnt_q < div_q));

  // R2: bit clock rises only at the start of a bit period
  a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> (div_cnt_q == '0));

  // R4: pulse shape is low outside the first bit of the frame
  a_r4_pulse_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && shape_q == WSHAPE_PULSE && bit_cnt_q != '0) |-> !wclk_o);

  // R6: disabled bit clock drive keeps the line low
  a_r6_bclk_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bm_q |-> !bclk_o);

  // R7: idle generator drives both lines low
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!bclk_o && !wclk_o));

  // R7: without a run request the generator stays idle
  a_r7_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !pwr_up_i && !keep_alive_i) |=> !active_q);

  // R8: stopping happens only at a frame boundary
  a_r8_stop_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(frame_end));

  // R10: settings frozen inside a frame
  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(frame_end)) |->
      ($stable(div_q) && $stable(frm_q) && $stable(shape_q) && $stable(bm_q) && $stable(wm_q)));

endmodule

bind audio_clkgen_top audio_clkgen_chk #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_up_i     (pwr_up_i),
  .keep_alive_i (keep_alive_i),
  .active_q     (active_q),
  .frame_end    (frame_end),
  .div_q        (div_q),
  .frm_q        (frm_q),
  .shape_q      (shape_q),
  .bm_q         (bm_q),
  .wm_q         (wm_q),
  .div_cnt_q    (div_cnt_q),
  .bit_cnt_q    (bit_cnt_q),
  .bclk_o       (bclk_o),
  .wclk_o       (wclk_o)
);

// File: tb/test_audio_clkgen_top.sv
`timescale 1ns/1ps
module test_audio_clkgen_top;

  localparam int DIV_W = 8;
  localparam int FRM_W = 8;
  localparam int VEC_N = 7;
  localparam int MEAS_CYC = 600;
  localparam int WATCHDOG = 100000;

  // stimulus: ratio, frame bits, square; expected: period, high, frame cycles, wclk high, rises per frame
  localparam int V_DIV [VEC_N] = '{4, 4, 3, 0, 1, 6, 2};
  localparam int V_FRM [VEC_N] = '{16, 16, 5, 8, 1, 7, 32};
  localparam int V_SQ  [VEC_N] = '{0, 1, 1, 0, 1, 0, 1};
  localparam int E_PER [VEC_N] = '{4, 4, 3, 2, 2, 6, 2};
  localparam int E_HI  [VEC_N] = '{2, 2, 1, 1, 1, 3, 1};
  localparam int E_FRC [VEC_N] = '{64, 64, 15, 16, 4, 42, 64};
  localparam int E_WHI [VEC_N] = '{4, 32, 6, 2, 2, 6, 32};
  localparam int E_RIS [VEC_N] = '{16, 16, 5, 8, 2, 7, 32};

  logic             clk;
  logic             rst_n;
  logic             pwr_up;
  logic             keep_alive;
  logic             bclk_master;
  logic             wclk_master;
  logic             wclk_square;
  logic [DIV_W-1:0] bclk_ratio;
  logic [FRM_W-1:0] frame_bits;
  logic             bclk;
  logic             wclk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc_cnt  = 0;
  logic b = 1'b0, w = 1'b0, pb = 1'b0, pw = 1'b0;

  audio_clkgen_top #(.DIV_W(DIV_W), .FRM_W(FRM_W)) i_audio_clkgen_top (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .pwr_up_i      (pwr_up),
    .keep_alive_i  (keep_alive),
    .bclk_master_i (bclk_master),
    .wclk_master_i (wclk_master),
    .wclk_square_i (wclk_square),
    .bclk_ratio_i  (bclk_ratio),
    .frame_bits_i  (frame_bits),
    .bclk_o        (bclk),
    .wclk_o        (wclk)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt >= WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc_cnt, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pb = b;
    pw = w;
    b  = bclk;
    w  = wclk;
  endtask

  task automatic go_idle();
    pwr_up     = 1'b0;
    keep_alive = 1'b0;
    for (int i = 0; i < MEAS_CYC; i++) step();
  endtask

  task automatic set_cfg(input int dv, input int fr, input int sq, input logic bm, input logic wm);
    bclk_ratio  = DIV_W'(dv);
    frame_bits  = FRM_W'(fr);
    wclk_square = sq[0];
    bclk_master = bm;
    wclk_master = wm;
  endtask

  task automatic count_rises(input int ncyc, output int br, output int wr);
    br = 0;
    wr = 0;
    for (int i = 0; i < ncyc; i++) begin
      step();
      if (b && !pb) br++;
      if (w && !pw) wr++;
    end
  endtask

  // called just after a word clock rise; counts bit rises up to the next one
  task automatic count_frame(output int n);
    n = 1;
    for (int i = 0; i < 4000; i++) begin
      step();
      if (w && !pw) return;
      if (b && !pb) n++;
    end
  endtask

  task automatic measure(output int per, output int hi, output int frc, output int whi, output int ris);
    int wr0, wr1, br0, br1;
    wr0 = -1; wr1 = -1; br0 = -1; br1 = -1;
    hi = -1; whi = -1; ris = 0;
    for (int c = 1; c <= MEAS_CYC; c++) begin
      step();
      if (w && !pw) begin
        if (wr0 < 0) wr0 = c;
        else if (wr1 < 0) wr1 = c;
      end
      if (!w && pw && wr0 >= 0 && whi < 0) whi = c - wr0;
      if (b && !pb) begin
        if (wr0 >= 0 && wr1 < 0) ris++;
        if (br0 < 0) br0 = c;
        else if (br1 < 0) br1 = c;
      end
      if (!b && pb && br0 >= 0 && hi < 0) hi = c - br0;
    end
    per = br1 - br0;
    frc = wr1 - wr0;
  endtask

  initial begin
    int per, hi, frc, whi, ris, br, wr, n;
    rst_n      = 1'b0;
    pwr_up     = 1'b1;
    keep_alive = 1'b0;
    set_cfg(4, 8, 0, 1'b1, 1'b1);

    // R11: reset holds both outputs low even with power up requested
    for (int i = 0; i < 4; i++) step();
    check("R11 reset bclk", int'(b), 0);
    check("R11 reset wclk", int'(w), 0);
    rst_n = 1'b1;
    go_idle();

    // table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < VEC_N; k++) begin
      go_idle();
      set_cfg(V_DIV[k], V_FRM[k], V_SQ[k], 1'b1, 1'b1);
      pwr_up = 1'b1;
      measure(per, hi, frc, whi, ris);
      check($sformatf("R1 period vec%0d", k), per, E_PER[k]);
      check($sformatf("R2 high time vec%0d", k), hi, E_HI[k]);
      check($sformatf("R3 frame cycles vec%0d", k), frc, E_FRC[k]);
      check($sformatf("R3 rises per frame vec%0d", k), ris, E_RIS[k]);
      if (V_SQ[k] != 0) check($sformatf("R5 square high vec%0d", k), whi, E_WHI[k]);
      else              check($sformatf("R4 pulse high vec%0d", k), whi, E_WHI[k]);
    end

    // R6: bit clock drive off, word clock still runs (frame 16 cycles)
    go_idle();
    set_cfg(4, 4, 0, 1'b0, 1'b1);
    pwr_up = 1'b1;
    count_rises(64, br, wr);
    check("R6 bclk off rises", br, 0);
    check("R6 wclk runs with bclk off", wr, 4);

    // R6: word clock drive off, bit clock still runs
    go_idle();
    set_cfg(4, 4, 0, 1'b1, 1'b0);
    pwr_up = 1'b1;
    count_rises(64, br, wr);
    check("R6 bclk runs with wclk off", br, 16);
    check("R6 wclk off rises", wr, 0);

    // R7: nothing requested -> nothing runs
    go_idle();
    set_cfg(4, 4, 0, 1'b1, 1'b1);
    count_rises(64, br, wr);
    check("R7 idle bclk rises", br, 0);
    check("R7 idle wclk rises", wr, 0);

    // R7: keep-alive runs clocks with converter down
    keep_alive = 1'b1;
    count_rises(64, br, wr);
    check("R7 keep-alive bclk rises", br, 16);
    check("R7 keep-alive wclk rises", wr, 4);

    // R8: stop requested right after frame start; frame 8 bits of ratio 2
    go_idle();
    set_cfg(2, 8, 0, 1'b1, 1'b1);
    pwr_up = 1'b1;
    step();
    // R9: first edge seeing the request starts a frame
    check("R9 start bclk high", int'(b), 1);
    check("R9 start wclk high", int'(w), 1);
    pwr_up = 1'b0;
    count_rises(60, br, wr);
    check("R8 remaining bit rises", br, 7);
    check("R8 no new frame", wr, 0);
    check("R8 bclk stops low", int'(b), 0);
    check("R8 wclk stops low", int'(w), 0);

    // R9: restart from idle
    pwr_up = 1'b1;
    step();
    check("R9 restart bclk high", int'(b), 1);
    check("R9 restart wclk high", int'(w), 1);

    // R10: frame length changed mid-frame applies from next frame
    frame_bits = FRM_W'(4);
    count_frame(n);
    check("R10 current frame keeps length", n, 8);
    count_frame(n);
    check("R10 next frame takes new length", n, 4);

    // R11: asynchronous reset while running
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b0;
    #1;
    check("R11 async reset bclk", int'(bclk), 0);
    check("R11 async reset wclk", int'(wclk), 0);
    step();
    check("R11 held in reset wclk", int'(w), 0);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule